// File: doc/BRIEF.md
# Programmable waveform state sequencer

A small microcoded interface engine. A byte-wide descriptor store holds several waveforms. Each waveform has seven programmable states and a fixed idle state (state 7). A state is either a timed hold state or a decision state. A hold state stays for a programmed number of clocks. A decision state picks its successor from a logic function of two selectable input flags. While a state is active, its output byte drives the control lines, and the state may capture the input data bus with a one-cycle FIFO write strobe.

A host first programs the descriptor store while the engine is idle. It then starts a run by presenting a waveform index and a pass count on the trigger interface, and polls the done flag. Each arrival at state 7 completes one pass. The engine restarts at state 0 until the requested number of passes has run, and then it rests idle with done high.

Top module: `wave_seq`

## Requirements
- R1: After reset, done_o is 1, fifo_we_o is 0, ctl_o equals idle_ctl_i, and every descriptor byte is 0.
- R2: Descriptor byte for waveform w, field f and state s sits at address w*32 + f*8 + s, with f = 0 length/branch, 1 opcode, 2 output, 3 logic. A write lands only in a cycle where done_o is 1; writes while busy are ignored. A write and a trigger in the same done cycle both take effect, and the run uses the new byte.
- R3: A trigger with nonzero trig_count_i while done_o is 1 starts the run: in the next cycle done_o is 0 and state 0 of the chosen waveform is active. A trigger with count 0, or any trigger while busy, is ignored.
- R4: A hold state (opcode bit 0 = 0) stays active for N clocks, where N is its length byte and 0 means 256, then state s+1 follows.
- R5: A decision state (opcode bit 0 = 1) with length bit 7 = 0 lasts one clock. It then goes to length bits 5:3 when the logic result is 1, else to bits 2:0.
- R6: A decision state with length bit 7 = 1 lasts two clocks, applying its output and sampling on both. The target is taken from the result in its first clock.
- R7: The logic byte selects the operator in bits 7:6 (0 AND, 1 OR, 2 XOR, 3 A AND NOT B), term A in bits 5:3 and term B in bits 2:0. Term codes 0-5 select rdy_i[code], 6 selects fifo_flag_i and 7 is 1 during the last pass.
- R8: Opcode bit 1 asserts fifo_we_o for one cycle on the first clock of a hold state, and on every clock of a decision state, with fifo_wdata_o equal to din_i in that cycle. Other opcode bits are ignored.
- R9: While busy, ctl_o is the active state's output byte; while done, it is idle_ctl_i.
- R10: Reaching state 7 ends a pass. If passes remain, state 0 follows in the next clock with no idle cycle; otherwise done_o rises in the next clock. A run executes exactly trig_count_i passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Descriptor byte write request |
| cfg_addr_i | input | 7 | Descriptor byte address |
| cfg_wdata_i | input | 8 | Descriptor byte value |
| trig_valid_i | input | 1 | Start request |
| trig_wave_i | input | 2 | Waveform index for the run |
| trig_count_i | input | 16 | Number of passes |
| done_o | output | 1 | High while idle |
| idle_ctl_i | input | 8 | Control line levels while idle |
| rdy_i | input | 6 | General ready flags, term codes 0-5 |
| fifo_flag_i | input | 1 | FIFO status flag, term code 6 |
| din_i | input | 16 | Data bus to be sampled |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 16 | Sampled data |
| ctl_o | output | 8 | Output-enable and control lines |

## Verification
A descriptor write and a trigger can fall in the same done cycle. The bench issues both together, with the write aimed at the output byte of state 0 of the triggered waveform. It then requires the first busy cycle to show the new byte. Across all runs, a cycle-level reference model computes ctl_o, fifo_we_o, fifo_wdata_o and done_o for every cycle, including writes and triggers that land while the engine is busy, which the model discards.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;

  localparam logic [2:0] IDLE_ST = 3'd7;

  typedef enum logic [1:0] {
    LF_AND  = 2'd0,
    LF_OR   = 2'd1,
    LF_XOR  = 2'd2,
    LF_ANDN = 2'd3
  } lf_op_e;

  // combine two terms according to the operator field
  function automatic logic lf_eval(input logic [1:0] op, input logic a, input logic b);
    logic r;
    unique case (lf_op_e'(op))
      LF_AND:  r = a & b;
      LF_OR:   r = a | b;
      LF_XOR:  r = a ^ b;
      default: r = a & ~b;
    endcase
    return r;
  endfunction

  // clocks spent in a hold state; zero encodes the longest hold
  function automatic logic [8:0] hold_len(input logic [7:0] v);
    return (v == 8'd0) ? 9'h100 : {1'b0, v};
  endfunction

endpackage

// File: rtl/wave_seq_mem.sv
module wave_seq_mem #(
  parameter int WW = 2,
  parameter int AW = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic               wr_allow_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [WW-1:0]      rd_wave_i,
  input  logic [2:0]         rd_state_i,
  output logic [3:0][7:0]    fld_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];
  logic       wr_fire;

  assign wr_fire = wr_en_i && wr_allow_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'd0;
    end else if (wr_fire) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  // one read port per field of the active state
  for (genvar f = 0; f < 4; f++) begin : g_fld
    assign fld_o[f] = mem[{rd_wave_i, 2'(f), rd_state_i}];
  end

  // checker: a blocked write must leave its byte untouched
  logic          blk_pend;
  logic [AW-1:0] blk_addr;
  logic [7:0]    blk_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_pend <= 1'b0;
      blk_addr <= '0;
      blk_val  <= 8'd0;
    end else begin
      blk_pend <= wr_en_i && !wr_allow_i;
      blk_addr <= wr_addr_i;
      blk_val  <= mem[wr_addr_i];
    end
  end

  // R2
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_pend |-> mem[blk_addr] == blk_val);

endmodule

// File: rtl/wave_seq_lfunc.sv
module wave_seq_lfunc
  import wave_seq_pkg::*;
(
  input  logic [7:0] lf_byte_i,
  input  logic [5:0] rdy_i,
  input  logic       fifo_flag_i,
  input  logic       last_pass_i,
  output logic       res_o
);
  logic [7:0] terms;
  logic       term_a, term_b;

  assign terms  = {last_pass_i, fifo_flag_i, rdy_i};
  assign term_a = terms[lf_byte_i[5:3]];
  assign term_b = terms[lf_byte_i[2:0]];
  assign res_o  = lf_eval(lf_byte_i[7:6], term_a, term_b);

endmodule

// File: rtl/wave_seq_engine.sv
module wave_seq_engine
  import wave_seq_pkg::*;
#(
  parameter int WW = 2,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_valid_i,
  input  logic [WW-1:0] trig_wave_i,
  input  logic [CW-1:0] trig_count_i,
  input  logic [7:0]    len_i,
  input  logic [7:0]    op_i,
  input  logic [7:0]    out_i,
  input  logic          lf_res_i,
  input  logic [7:0]    idle_ctl_i,
  input  logic [DW-1:0] din_i,
  output logic          busy_o,
  output logic [2:0]    state_o,
  output logic [WW-1:0] wave_o,
  output logic          last_pass_o,
  output logic          fifo_we_o,
  output logic [DW-1:0] fifo_wdata_o,
  output logic [7:0]    ctl_o
);
  logic          busy_q;
  logic [2:0]    st_q, tgt_q;
  logic [8:0]    cnt_q;
  logic [CW-1:0] pass_q;
  logic [WW-1:0] wave_q;

  // named internal events
  logic       is_dec, first_clk, reexec, hold_done;
  logic       start_w, leave_w, pass_end_w;
  logic [2:0] lf_tgt, nxt_st;

  assign is_dec     = op_i[0];
  assign reexec     = len_i[7];
  assign first_clk  = (cnt_q == 9'd0);
  assign hold_done  = (cnt_q == hold_len(len_i) - 9'd1);
  assign lf_tgt     = lf_res_i ? len_i[5:3] : len_i[2:0];
  assign start_w    = !busy_q && trig_valid_i && (trig_count_i != '0);
  assign last_pass_o = (pass_q == CW'(1));

  always_comb begin
    leave_w = 1'b0;
    nxt_st  = st_q + 3'd1;
    if (busy_q) begin
      if (is_dec) begin
        leave_w = !(reexec && first_clk);
        nxt_st  = reexec ? tgt_q : lf_tgt;
      end else begin
        leave_w = hold_done;
      end
    end
  end

  assign pass_end_w = leave_w && (nxt_st == IDLE_ST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      st_q   <= 3'd0;
      tgt_q  <= 3'd0;
      cnt_q  <= 9'd0;
      pass_q <= '0;
      wave_q <= '0;
    end else if (start_w) begin
      busy_q <= 1'b1;
      st_q   <= 3'd0;
      cnt_q  <= 9'd0;
      pass_q <= trig_count_i;
      wave_q <= trig_wave_i;
    end else if (busy_q) begin
      if (leave_w) begin
        cnt_q <= 9'd0;
        if (pass_end_w) begin
          st_q <= 3'd0;
          if (last_pass_o) busy_q <= 1'b0;
          else             pass_q <= pass_q - CW'(1);
        end else begin
          st_q <= nxt_st;
        end
      end else begin
        cnt_q <= cnt_q + 9'd1;
        if (is_dec) tgt_q <= lf_tgt;
      end
    end
  end

  assign busy_o       = busy_q;
  assign state_o      = st_q;
  assign wave_o       = wave_q;
  assign fifo_we_o    = busy_q && op_i[1] && (is_dec || first_clk);
  assign fifo_wdata_o = din_i;
  assign ctl_o        = busy_q ? out_i : idle_ctl_i;

  // R3
  start_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> busy_q && st_q == 3'd0 && cnt_q == 9'd0);

  // R3
  busy_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && trig_valid_i && !pass_end_w |=> pass_q == $past(pass_q));

  // R4
  hold_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !is_dec && !hold_done |=> st_q == $past(st_q) && cnt_q == $past(cnt_q) + 9'd1);

  // R6
  reexec_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && is_dec && reexec && first_clk |=> busy_q && st_q == $past(st_q) && cnt_q == 9'd1);

  // R8
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_we_o |-> busy_q && st_q != IDLE_ST);

  // R10
  last_pass_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(pass_q) == CW'(1));

endmodule

// File: rtl/wave_seq.sv
module wave_seq
  import wave_seq_pkg::*;
#(
  parameter int NWAVE = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  localparam int WW   = $clog2(NWAVE),
  localparam int AW   = WW + 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [7:0]    cfg_wdata_i,
  input  logic          trig_valid_i,
  input  logic [WW-1:0] trig_wave_i,
  input  logic [CW-1:0] trig_count_i,
  output logic          done_o,
  input  logic [7:0]    idle_ctl_i,
  input  logic [5:0]    rdy_i,
  input  logic          fifo_flag_i,
  input  logic [DW-1:0] din_i,
  output logic          fifo_we_o,
  output logic [DW-1:0] fifo_wdata_o,
  output logic [7:0]    ctl_o
);
  logic [3:0][7:0] fld;
  logic            busy, last_pass, lf_res;
  logic [2:0]      cur_st;
  logic [WW-1:0]   cur_wave;

  assign done_o = !busy;

  wave_seq_mem #(.WW(WW), .AW(AW)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (cfg_we_i),
    .wr_allow_i (!busy),
    .wr_addr_i  (cfg_addr_i),
    .wr_data_i  (cfg_wdata_i),
    .rd_wave_i  (cur_wave),
    .rd_state_i (cur_st),
    .fld_o      (fld)
  );

  wave_seq_lfunc u_lfunc (
    .lf_byte_i   (fld[3]),
    .rdy_i       (rdy_i),
    .fifo_flag_i (fifo_flag_i),
    .last_pass_i (last_pass),
    .res_o       (lf_res)
  );

  wave_seq_engine #(.WW(WW), .CW(CW), .DW(DW)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_valid_i (trig_valid_i),
    .trig_wave_i  (trig_wave_i),
    .trig_count_i (trig_count_i),
    .len_i        (fld[0]),
    .op_i         (fld[1]),
    .out_i        (fld[2]),
    .lf_res_i     (lf_res),
    .idle_ctl_i   (idle_ctl_i),
    .din_i        (din_i),
    .busy_o       (busy),
    .state_o      (cur_st),
    .wave_o       (cur_wave),
    .last_pass_o  (last_pass),
    .fifo_we_o    (fifo_we_o),
    .fifo_wdata_o (fifo_wdata_o),
    .ctl_o        (ctl_o)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !fifo_we_o && ctl_o == idle_ctl_i);

endmodule

// File: tb/wave_seq_tb_top.sv
module wave_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [6:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        trig_valid_i = 1'b0;
  logic [1:0]  trig_wave_i = '0;
  logic [15:0] trig_count_i = '0;
  logic        done_o;
  logic [7:0]  idle_ctl_i = 8'h5A;
  logic [5:0]  rdy_i = '0;
  logic        fifo_flag_i = 1'b0;
  logic [15:0] din_i = '0;
  logic        fifo_we_o;
  logic [15:0] fifo_wdata_o;
  logic [7:0]  ctl_o;

  always #5 clk = ~clk;

  wave_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .trig_valid_i(trig_valid_i), .trig_wave_i(trig_wave_i),
    .trig_count_i(trig_count_i), .done_o(done_o), .idle_ctl_i(idle_ctl_i),
    .rdy_i(rdy_i), .fifo_flag_i(fifo_flag_i), .din_i(din_i), .fifo_we_o(fifo_we_o),
    .fifo_wdata_o(fifo_wdata_o), .ctl_o(ctl_o)
  );

  int errs = 0, checks = 0, cyc = 0;
  int flag_pct = 50;
  bit finished = 0;

  // pending one-cycle stimulus
  logic        p_we = 0, p_trig = 0;
  logic [6:0]  p_addr = '0;
  logic [7:0]  p_wdata = '0;
  logic [1:0]  p_wave = '0;
  logic [15:0] p_count = '0;

  // observations of the last stepped cycle
  logic [7:0] obs_ctl;
  logic       obs_we, obs_done;

  // reference model
  logic [7:0] mir [128];
  bit         mb = 0;
  int         ms = 0, mc = 0, mp = 0, mw = 0;
  logic [2:0] mt = '0;
  string      mtag = "R9";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit term_ref(logic [2:0] c, logic [5:0] r, logic ff, bit lastp);
    if (c == 3'd7) return lastp;
    if (c == 3'd6) return ff;
    return r[c];
  endfunction

  function automatic bit lf_ref(logic [7:0] lf, logic [5:0] r, logic ff, bit lastp);
    bit a = term_ref(lf[5:3], r, ff, lastp);
    bit b = term_ref(lf[2:0], r, ff, lastp);
    case (lf[7:6])
      2'd0: return a && b;
      2'd1: return a || b;
      2'd2: return a != b;
      default: return a && !b;
    endcase
  endfunction

  function automatic void go(int n, string tg);
    mc = 0;
    if (n == 7) begin
      ms = 0;
      if (mp == 1) begin mb = 0; mtag = "R9"; end
      else begin mp--; mtag = "R10"; end
    end else begin
      ms = n; mtag = tg;
    end
  endfunction

  task automatic step();
    logic [7:0] e_ctl, op, len, lf;
    logic       e_we;
    logic [2:0] t;
    int b;
    @(negedge clk);
    rdy_i = 6'($urandom);
    fifo_flag_i = (int'($urandom % 100) < flag_pct);
    din_i = 16'($urandom);
    cfg_we_i = p_we; cfg_addr_i = p_addr; cfg_wdata_i = p_wdata;
    trig_valid_i = p_trig; trig_wave_i = p_wave; trig_count_i = p_count;
    p_we = 0; p_trig = 0;
    #1;
    b = mw * 32;
    if (mb) begin
      op = mir[b + 8 + ms];
      e_ctl = mir[b + 16 + ms];
      e_we = op[1] && (op[0] || mc == 0);
    end else begin
      e_ctl = idle_ctl_i;
      e_we = 1'b0;
    end
    chk(mtag, int'(ctl_o), int'(e_ctl));
    chk("R8", int'(fifo_we_o), int'(e_we));
    if (e_we) chk("R8", int'(fifo_wdata_o), int'(din_i));
    chk("R10", int'(done_o), int'(!mb));
    obs_ctl = ctl_o; obs_we = fifo_we_o; obs_done = done_o;
    cyc++;
    @(posedge clk);
    if (cfg_we_i && !mb) mir[cfg_addr_i] = cfg_wdata_i;
    if (!mb) begin
      if (trig_valid_i && trig_count_i != 0) begin
        mb = 1; ms = 0; mc = 0; mp = int'(trig_count_i); mw = int'(trig_wave_i); mtag = "R3";
      end
    end else begin
      len = mir[b + ms]; op = mir[b + 8 + ms]; lf = mir[b + 24 + ms];
      if (op[0]) begin
        t = lf_ref(lf, rdy_i, fifo_flag_i, mp == 1) ? len[5:3] : len[2:0];
        if (len[7] && mc == 0) begin mt = t; mc = 1; mtag = "R6"; end
        else if (len[7]) go(int'(mt), "R6");
        else go(int'(t), "R7");
      end else begin
        if (mc == ((len == 0) ? 256 : int'(len)) - 1) go(ms + 1, "R4");
        else mc++;
      end
    end
  endtask

  task automatic wr(int addr, logic [7:0] v);
    p_we = 1; p_addr = 7'(addr); p_wdata = v;
    step();
  endtask

  task automatic prog(int w, int s, logic [7:0] len, logic [7:0] op, logic [7:0] out, logic [7:0] lf);
    wr(w*32 + s, len); wr(w*32 + 8 + s, op); wr(w*32 + 16 + s, out); wr(w*32 + 24 + s, lf);
  endtask

  task automatic fill_plain(int w);
    for (int s = 0; s < 7; s++) prog(w, s, 8'd1, 8'd0, 8'd0, 8'd0);
  endtask

  task automatic trig(int w, int n);
    p_trig = 1; p_wave = 2'(w); p_count = 16'(n);
  endtask

  task automatic finish_run(output int strobes);
    strobes = 0;
    step();
    if (obs_we) strobes++;
    while (mb) begin
      step();
      if (obs_we) strobes++;
    end
    step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog R10 act=running exp=done");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int n, t0;
    void'($urandom(32'd7));
    for (int i = 0; i < 128; i++) mir[i] = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1", int'(done_o), 1);
    chk("R1", int'(fifo_we_o), 0);
    chk("R1", int'(ctl_o), int'(idle_ctl_i));

    // doc-like loop: sample, then branch to idle on full flag else back
    flag_pct = 10;
    fill_plain(0);
    prog(0, 0, 8'd3, 8'h02, 8'h11, 8'h00);
    prog(0, 1, 8'h38, 8'h03, 8'h12, 8'h36);
    trig(0, 2);
    finish_run(n);

    // R4: zero length means 256 clocks
    flag_pct = 50;
    fill_plain(1);
    prog(1, 0, 8'd0, 8'h02, 8'h22, 8'h00);
    prog(1, 1, 8'd1, 8'h02, 8'h33, 8'h00);
    trig(1, 1);
    t0 = -1;
    step();
    for (int k = 0; k < 400 && mb; k++) begin
      step();
      if (k == 10) begin
        wr(32 + 16, 8'hEE); // blocked: engine busy
      end
      if (obs_we && obs_ctl == 8'h22) t0 = cyc;
      if (obs_we && obs_ctl == 8'h33) chk("R4", cyc - t0, 256);
    end
    while (mb) step();
    step();
    // R2: blocked write left the byte alone
    trig(1, 1);
    step(); step();
    chk("R2", int'(obs_ctl), 8'h22);
    while (mb) step();
    step();
    // R2: write and trigger in the same done cycle
    p_we = 1; p_addr = 7'(32 + 16); p_wdata = 8'h44;
    trig(1, 1);
    step(); step();
    chk("R2", int'(obs_ctl), 8'h44);
    while (mb) step();
    step();

    // R3: zero count ignored
    trig(1, 0);
    step(); step();
    chk("R3", int'(obs_done), 1);

    // R5 / R6 / R10 strobe counts
    fill_plain(2);
    prog(2, 0, 8'h3F, 8'h03, 8'h55, 8'h00);
    trig(2, 1); finish_run(n); chk("R5", n, 1);
    prog(2, 0, 8'hBF, 8'h03, 8'h55, 8'h00);
    trig(2, 1); finish_run(n); chk("R6", n, 2);
    prog(2, 0, 8'h3F, 8'h03, 8'h55, 8'h00);
    trig(2, 3); finish_run(n); chk("R10", n, 3);

    // R7: each operator with A = fifo flag, B = last pass (1)
    fill_plain(3);
    prog(3, 1, 8'd1, 8'h00, 8'hA0, 8'h00);
    prog(3, 2, 8'd1, 8'h00, 8'hB0, 8'h00);
    for (int op = 0; op < 4; op++) begin
      for (int ff = 0; ff < 2; ff++) begin
        bit r;
        prog(3, 0, 8'h11, 8'h01, 8'h01, 8'((op << 6) | (6 << 3) | 7));
        flag_pct = ff * 100;
        r = (op == 0) ? ff == 1 : (op == 1) ? 1'b1 : (op == 2) ? ff == 0 : 1'b0;
        trig(3, 1);
        step(); step(); step();
        chk("R7", int'(obs_ctl), r ? 8'hB0 : 8'hA0);
        while (mb) step();
        step();
      end
    end
    flag_pct = 50;

    // random forward-only programs, some with busy triggers and writes
    for (int it = 0; it < 30; it++) begin
      int w = int'($urandom % 4);
      for (int s = 0; s < 7; s++) begin
        bit dec = 1'($urandom);
        logic [7:0] len, op;
        if (dec) len = {1'($urandom), 1'($urandom),
                        3'(s + 1 + int'($urandom % (7 - s))),
                        3'(s + 1 + int'($urandom % (7 - s)))};
        else len = 8'(1 + $urandom % 4);
        op = (8'($urandom) & 8'hFE) | 8'(dec);
        prog(w, s, len, op, 8'($urandom), 8'($urandom));
      end
      idle_ctl_i = 8'($urandom);
      trig(w, 1 + int'($urandom % 3));
      step();
      if (it % 5 == 0) trig(w, 9);
      if (it % 7 == 0) begin p_we = 1; p_addr = 7'(w*32 + 16); p_wdata = 8'($urandom); end
      while (mb) step();
      step();
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule